// File: doc/BRIEF.md
# Three-Channel Programmable Interval Counter

This block is a byte-wide peripheral that a host reaches through a small register window. It holds three independent 16-bit down-counters and one control register that they share. The host writes a control word to pick a channel, a byte access pattern, a counting mode and binary or decimal counting. It then loads the initial count one byte at a time. Each channel drives one output line. Mode 2 gives a periodic one-clock low pulse. Mode 3 gives a square wave.

To read a channel, the host first issues a latch command, which freezes a snapshot of the running count. It then reads the snapshot back as bytes. A read-back command instead arms a status byte for one or more channels. The status byte reports the output level, whether the last written count has reached the counter yet, and the programmed control bits. Register offsets are spread across the address space by a shift parameter, so the block can sit on buses whose registers are 2 or 4 bytes apart.

Top module: `tri_interval_timer`

## Requirements
- R1: The register index is taken from address bits [REGSHIFT+1:REGSHIFT], and address bits below them are ignored. Index 0, 1 and 2 are the data registers of channels 0, 1 and 2. Index 3 is the control register, and a read from index 3 returns 0x00.
- R2: Control word layout: [7:6] is the channel, [5:4] is the access pattern, [3:1] is the mode and [0] selects BCD when it is 1. Access pattern 01 moves only the low byte and loads the high byte as zero. Pattern 10 moves only the high byte and loads the low byte as zero. Pattern 11 moves the low byte and then the high byte. Writing a programming word (pattern not 00, channel not 3) has these effects on that channel: its write and read byte order restart at the low byte, it stops counting, it drops any pending snapshot, its error flag clears, its null-count flag sets, and its output goes low for mode 0 and high for every other mode.
- R3: With pattern 11 the byte-order state is kept between the two byte writes, whatever other accesses fall between them. A completed count is moved into an idle counter on the next clock.
- R4: In mode 2 (mode field 010 or 110) with count N, the output is low for exactly one clock in every N clocks. If the count completes at clock edge E, a snapshot taken at edge L ≥ E+2 reads N − ((L−E−2) mod N).
- R5: In mode 3 (mode field 011 or 111) with count N, the output stays high for ceil(N/2) clocks and low for floor(N/2) clocks, and this repeats.
- R6: A loaded count of zero means 65536 in binary counting and 10000 in BCD counting.
- R7: With BCD selected, both the loaded count and the values read back are four packed decimal digits.
- R8: Loading a count of 1 in mode 2 or 3 sets that channel's bit of bad_count, and the count is not used: an idle counter stays idle and the null-count flag stays set. The bit clears on the next legal count load or programming word for that channel. Only a host write can set or clear it.
- R9: A latch command (pattern 00) holds the channel's current count until the host has read it with that channel's access pattern. The counter keeps running meanwhile. A further latch command before the read is complete is ignored.
- R10: The read-back command is a control byte with [7:6]=11 and [5:4]=10. Bit 1+n arms the status byte of channel n. The next read of that channel returns {output level, null-count, control bits [5:0]}. This takes priority over count bytes and does not disturb the count byte order. The null-count flag clears when the count reaches the counter.
- R11: After reset every channel holds control bits 110000 (pattern 11, mode 0, binary). Each output is low, each null-count flag is set, no error flag is set, and rdata is 0x00.
- R12: Read data appears on rdata on the clock after rd_en and holds until the next read.
- R13: In modes other than 2 and 3 a loaded count is moved into the counter but does not count down, and the output stays at the level set by the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | REGSHIFT+2 | Register address; index in bits [REGSHIFT+1:REGSHIFT] |
| wr_en | input | 1 | Write strobe for one clock |
| wdata | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe for one clock |
| rdata | output | 8 | Registered read data byte |
| wave | output | 3 | Output line of each channel |
| bad_count | output | 3 | Per-channel flag for an illegal count of 1 |

## Verification
Two host actions can land on the same clock edge as a mode-2 terminal-count reload: a latch command, or the final byte of a count write. The bench keeps a free-running edge counter and places the latch command exactly on the reload edge. The snapshot must hold the pre-reload value 1, and a later snapshot must still follow the N − ((L−E−2) mod N) formula. That shows the reload was neither skipped nor doubled by the concurrent command.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter int REGSHIFT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGSHIFT+1:0] addr,
  input  logic                wr_en,
  input  logic [7:0]          wdata,
  input  logic                rd_en,
  output logic [7:0]          rdata,
  output logic [2:0]          wave,
  output logic [2:0]          bad_count
);

  localparam int NCH = 3;
  localparam logic [16:0] FULL_BIN = 17'd65536;
  localparam logic [16:0] FULL_BCD = 17'd10000;

  function automatic logic [16:0] bcd_to_bin(input logic [15:0] b);
    return 17'(b[15:12]) * 17'd1000 + 17'(b[11:8]) * 17'd100
         + 17'(b[7:4]) * 17'd10 + 17'(b[3:0]);
  endfunction

  function automatic logic [15:0] bin_to_bcd(input logic [16:0] v);
    logic [16:0] t;
    t = v % 17'd10000;
    return {4'(t / 17'd1000), 4'((t / 17'd100) % 17'd10),
            4'((t / 17'd10) % 17'd10), 4'(t % 17'd10)};
  endfunction

  wire [1:0] idx    = addr[REGSHIFT +: 2];
  wire       ctl_wr = wr_en && idx == 2'd3;
  wire       rb_cmd = ctl_wr && wdata[7:6] == 2'b11 && wdata[5:4] == 2'b10;

  logic [7:0] rbyte [4];
  assign rbyte[3] = 8'h00;

  for (genvar n = 0; n < NCH; n++) begin : ch
    logic [5:0]  ctrl;
    logic [15:0] cr, lat;
    logic [16:0] ce, rl;
    logic [7:0]  st;
    logic wr_hi, rd_hi, latched, st_pend, nul, pend, run, out, err;

    wire [1:0]  acc      = ctrl[5:4];
    wire        is23     = ctrl[2];
    wire        sq       = ctrl[2] & ctrl[1];
    wire        my_cw    = ctl_wr && wdata[7:6] == 2'(n);
    wire        do_latch = my_cw && wdata[5:4] == 2'b00;
    wire        do_prog  = my_cw && wdata[5:4] != 2'b00;
    wire        do_rb    = rb_cmd && wdata[n+1];
    wire        dwr      = wr_en && idx == 2'(n);
    wire        drd      = rd_en && idx == 2'(n);

    wire [16:0] cr_bin = ctrl[0] ? bcd_to_bin(cr) : {1'b0, cr};
    wire [16:0] nfull  = (cr == 16'd0) ? (ctrl[0] ? FULL_BCD : FULL_BIN) : cr_bin;
    wire [16:0] nv     = pend ? nfull : rl;
    wire [15:0] now16  = ctrl[0] ? bin_to_bcd(ce) : ce[15:0];
    wire [15:0] src    = latched ? lat : now16;
    wire        last_b = acc != 2'b11 || rd_hi;
    wire        hi_sel = acc == 2'b10 || (acc == 2'b11 && rd_hi);
    wire [15:0] cr_new = acc == 2'b01 ? {8'h00, wdata} :
                         acc == 2'b10 ? {wdata, 8'h00} : {wdata, cr[7:0]};

    assign rbyte[n]     = st_pend ? st : (hi_sel ? src[15:8] : src[7:0]);
    assign wave[n]      = out;
    assign bad_count[n] = err;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl <= 6'b110000;
        cr <= '0; lat <= '0; ce <= '0; rl <= '0; st <= '0;
        wr_hi <= 1'b0; rd_hi <= 1'b0; latched <= 1'b0; st_pend <= 1'b0;
        nul <= 1'b1; pend <= 1'b0; run <= 1'b0; out <= 1'b0; err <= 1'b0;
      end else begin
        if (run) begin
          if (ce == 17'd1) begin
            if (sq && out) ce <= rl >> 1;
            else begin
              ce <= sq ? (nv + 17'd1) >> 1 : nv;
              if (pend) begin
                rl <= nfull; pend <= 1'b0; nul <= 1'b0;
              end
            end
            out <= sq ? ~out : 1'b1;
          end else begin
            ce <= ce - 17'd1;
            if (!sq && ce == 17'd2) out <= 1'b0;
          end
        end else if (pend) begin
          pend <= 1'b0; nul <= 1'b0; rl <= nfull;
          ce   <= sq ? (nfull + 17'd1) >> 1 : nfull;
          run  <= is23;
        end

        if (drd) begin
          if (st_pend) st_pend <= 1'b0;
          else begin
            if (acc == 2'b11) rd_hi <= ~rd_hi;
            if (last_b) latched <= 1'b0;
          end
        end
        if (do_latch && !latched) begin
          lat <= now16; latched <= 1'b1;
        end
        if (do_rb && !st_pend) begin
          st <= {out, nul, ctrl}; st_pend <= 1'b1;
        end

        if (dwr) begin
          if (acc == 2'b11 && !wr_hi) begin
            cr[7:0] <= wdata; wr_hi <= 1'b1;
          end else begin
            cr <= cr_new; wr_hi <= 1'b0;
            if (is23 && cr_new == 16'd1) err <= 1'b1;
            else begin
              err <= 1'b0; pend <= 1'b1; nul <= 1'b1;
            end
          end
        end

        if (do_prog) begin
          ctrl <= wdata[5:0];
          wr_hi <= 1'b0; rd_hi <= 1'b0; latched <= 1'b0;
          nul <= 1'b1; pend <= 1'b0; run <= 1'b0; err <= 1'b0;
          out <= wdata[3:1] != 3'd0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en) rdata <= rbyte[idx];
  end

endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int REGSHIFT = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [REGSHIFT+1:0] addr,
  input logic                wr_en,
  input logic [7:0]          wdata,
  input logic                rd_en,
  input logic [7:0]          rdata,
  input logic [2:0]          wave,
  input logic [2:0]          bad_count
);

  wire prog_wr = wr_en && addr[REGSHIFT +: 2] == 2'd3 &&
                 wdata[7:6] != 2'b11 && wdata[5:4] != 2'b00;

  // R11
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (wave == 3'b000 && bad_count == 3'b000 && rdata == 8'h00));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count & ~$past(bad_count)) != 3'b000 |-> $past(wr_en));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bad_count));

  // R2
  prog_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr |=> (bad_count & (3'b001 << $past(wdata[7:6]))) == 3'b000);

  // R2
  mode0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_wr && wdata[3:1] == 3'd0) |=> (wave & (3'b001 << $past(wdata[7:6]))) == 3'b000);

endmodule

bind tri_interval_timer tri_interval_timer_chk #(.REGSHIFT(REGSHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .wave(wave), .bad_count(bad_count)
);

// File: tb/tri_interval_timer_tb_top.sv
module tri_interval_timer_tb_top;
  localparam int RS = 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [RS+1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wdata = 8'h00;
  wire  [7:0]    rdata;
  wire  [2:0]    wave, bad_count;

  int n_chk = 0, n_bad = 0, cyc = 0, last_edge = 0;
  bit done = 1'b0;

  tri_interval_timer #(.REGSHIFT(RS)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .wave(wave), .bad_count(bad_count)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_at(input int off, input logic [7:0] d, input int target, input bit junk = 1'b0);
    while (cyc < target - 1) @(negedge clk);
    addr = (RS+2)'((off << RS) | int'(junk));
    wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; last_edge = cyc;
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    wr_at(off, d, cyc + 2);
  endtask

  task automatic rd(input int off, output int v, input bit junk = 1'b0);
    @(negedge clk);
    addr = (RS+2)'((off << RS) | int'(junk));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; v = rdata;
  endtask

  task automatic latch2(input int c, input int target, output int v);
    int lo, hi;
    wr_at(3, 8'(c << 6), target);
    rd(c, lo); rd(c, hi);
    v = hi * 256 + lo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    chk("R11 wave", wave, 0);
    chk("R11 bad_count", bad_count, 0);
    chk("R11 rdata", rdata, 0);
    wr(3, 8'hEE);
    for (int c = 0; c < 3; c++) begin
      rd(c, v);
      chk("R11 R10 reset status", v, 8'h70);
    end
  endtask

  task automatic t_decode;
    int v;
    wr_at(3, 8'h34, cyc + 2, 1'b1);
    wr(3, 8'hE2);
    rd(0, v, 1'b1);
    chk("R1 R2 status via shifted address", v, 8'hF4);
    rd(3, v);
    chk("R1 R12 control read", v, 0);
  endtask

  task automatic t_mode2;
    int v, e, l, lows, dbl;
    logic p;
    wr(0, 8'h05);
    rd(2, v);
    wr(0, 8'h00);
    e = last_edge;
    latch2(0, e + 9, v);
    chk("R3 R4 R9 snapshot", v, 3);
    l = cyc + 4;
    latch2(0, l, v);
    chk("R4 R9 counter kept running", v, 5 - ((l - e - 2) % 5));
    wr(3, 8'hE2);
    rd(0, v);
    chk("R10 null cleared after transfer", v & 8'h7F, 8'h34);
    lows = 0; dbl = 0; p = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (!wave[0]) begin lows++; if (!p) dbl++; end
      p = wave[0];
    end
    chk("R4 low pulses in 25 clocks", lows, 5);
    chk("R4 pulse width", dbl, 0);
    l = cyc + 2;
    while ((l - e - 2) % 5 != 4) l++;
    latch2(0, l, v);
    chk("R9 R4 latch on reload edge", v, 1);
    l = cyc + 3;
    latch2(0, l, v);
    chk("R4 reload after concurrent latch", v, 5 - ((l - e - 2) % 5));
  endtask

  task automatic check_square(input int c, input int hi, input int lo, input string req);
    int run, bad, nh, nl;
    logic prev;
    bit first;
    run = 0; bad = 0; nh = 0; nl = 0; first = 1'b1; prev = wave[c];
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wave[c] == prev) run++;
      else begin
        if (!first) begin
          if (prev) begin nh++; if (run != hi) bad++; end
          else begin nl++; if (run != lo) bad++; end
        end
        first = 1'b0; prev = wave[c]; run = 1;
      end
    end
    chk({req, " phase length errors"}, bad, 0);
    chk({req, " phases seen"}, int'(nh >= 2 && nl >= 2), 1);
  endtask

  task automatic t_mode3;
    int v;
    wr(3, 8'h76);
    wr(3, 8'hE4);
    rd(1, v);
    chk("R2 R10 status before load", v, 8'hF6);
    wr(1, 8'h05); wr(1, 8'h00);
    check_square(1, 3, 2, "R5 odd count");
    wr(3, 8'hB6);
    wr(2, 8'h04); wr(2, 8'h00);
    check_square(2, 2, 2, "R5 even count");
  endtask

  task automatic t_zero_bcd;
    int v, e;
    wr(3, 8'hB4);
    wr(2, 8'h00); wr(2, 8'h00);
    e = last_edge;
    latch2(2, e + 7, v);
    chk("R6 binary zero is 65536", v, 16'hFFFB);
    wr(3, 8'hB5);
    wr(2, 8'h00); wr(2, 8'h00);
    e = last_edge;
    latch2(2, e + 7, v);
    chk("R6 R7 BCD zero is 10000", v, 16'h9995);
    wr(3, 8'hB5);
    wr(2, 8'h12); wr(2, 8'h00);
    e = last_edge;
    latch2(2, e + 4, v);
    chk("R7 BCD snapshot", v, 16'h0010);
    latch2(2, e + 15, v);
    chk("R7 BCD after reload", v, 16'h0011);
  endtask

  task automatic t_illegal;
    int v, lows;
    wr(3, 8'h34);
    wr(0, 8'h01); wr(0, 8'h00);
    chk("R8 flag set mode 2", bad_count[0], 1);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!wave[0]) lows++;
    end
    chk("R8 no counting with 1", lows, 0);
    wr(3, 8'hE2);
    rd(0, v);
    chk("R8 null stays set", v, 8'hF4);
    wr(3, 8'h34);
    chk("R8 R2 control word clears flag", bad_count[0], 0);
    wr(3, 8'h56);
    wr(1, 8'h01);
    chk("R8 flag set mode 3 low-only", bad_count[1], 1);
    wr(1, 8'h04);
    chk("R8 legal load clears flag", bad_count[1], 0);
  endtask

  task automatic t_patterns;
    int v, e;
    wr(3, 8'h64);
    wr(1, 8'h01);
    e = last_edge;
    wr_at(3, 8'h40, e + 2);
    rd(1, v);
    chk("R2 high-only access", v, 8'h01);
    wr(3, 8'h54);
    wr(1, 8'h09);
    e = last_edge;
    wr_at(3, 8'h40, e + 5);
    rd(1, v);
    chk("R2 low-only access", v, 8'h06);
  endtask

  task automatic t_flipflop;
    int v;
    wr(3, 8'h34);
    wr(0, 8'hAA);
    wr(3, 8'h34);
    wr(0, 8'h07); wr(0, 8'h00);
    latch2(0, last_edge + 2, v);
    chk("R2 R3 control word restarts byte order", v, 7);
  endtask

  task automatic t_mode0_status;
    int v;
    wr(3, 8'hB0);
    chk("R13 mode 0 output low", wave[2], 0);
    wr(2, 8'h34); wr(2, 8'h12);
    idle(5);
    wr(3, 8'h80);
    wr(3, 8'hE8);
    rd(2, v);
    chk("R10 status before latched count", v, 8'h30);
    rd(2, v);
    chk("R13 R9 idle count low byte", v, 8'h34);
    rd(2, v);
    chk("R13 R9 idle count high byte", v, 8'h12);
    chk("R13 output held", wave[2], 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_decode();
    t_mode2();
    t_mode3();
    t_zero_bcd();
    t_illegal();
    t_patterns();
    t_flipflop();
    t_mode0_status();
    done = 1'b1;
    finish_run();
  end
endmodule